// File: doc/BRIEF.md
# Lockable Protection Status Register

This block is the status register and write-permission logic of a serial flash memory. It holds a busy flag, a write-enable latch, a two-bit protection-level field and a lock-down bit. It takes decoded command strobes from the command decoder: set-enable, clear-enable, write-status and read-status. It decides whether a status write may take effect. It also turns the protection level into a protected address range that the program and erase path can query.

A status write succeeds only when three conditions hold: the enable latch is set, no internal operation is running, and the register is not locked. The register is locked when the lock-down bit is 1 and the write-protect pin (`wp_n`, active low) is driven low. With the pin high, the lock-down bit has no effect. The memory array and the program engine lie outside this block. The engine reports its state through `engine_busy`.

Top module: `flash_status_guard`

## Requirements
- R1: After a synchronous reset, the status register, `status_byte` and `addr_protected` are all zero.
- R2: The status layout is: bit 0 busy, bit 1 write-enable latch, bits 3:2 protection level, bit 7 lock-down, and bits 6:4 always read 0. The busy bit equals `engine_busy` delayed by one clock, and a status write cannot change busy.
- R3: `cmd_wren` sets the write-enable latch and `cmd_wrdi` clears it.
- R4: A permitted `cmd_wrsr` loads bits 7 and 3:2 from `wr_value` at the same bit positions and clears the write-enable latch. The other bits of `wr_value` are ignored. If the latch is clear, `cmd_wrsr` leaves the register unchanged.
- R5: With `wp_n` low and lock-down set, `cmd_wrsr` is refused: the register, including the enable latch, is unchanged.
- R6: With `wp_n` low and lock-down clear, `cmd_wrsr` is executed.
- R7: With `wp_n` high, `cmd_wrsr` is executed whatever the lock-down bit holds.
- R8: While the busy bit is set, `cmd_wren`, `cmd_wrdi` and `cmd_wrsr` have no effect.
- R9: `cmd_rdsr` copies the status register into `status_byte` on the next clock edge. `status_byte` holds that value until the next `cmd_rdsr`.
- R10: For a 2^ADDR_W byte array, the protection level decodes as follows: 00 protects nothing; 01 protects the top quarter (address bits [MSB:MSB-1] = 11); 10 protects the top half (address MSB = 1); 11 protects everything.
- R11: `addr_protected` is registered. It reflects `chk_addr` and the protection level one clock after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren | input | 1 | Set-enable command strobe |
| cmd_wrdi | input | 1 | Clear-enable command strobe |
| cmd_wrsr | input | 1 | Write-status command strobe |
| cmd_rdsr | input | 1 | Read-status command strobe |
| wr_value | input | 8 | Value for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| engine_busy | input | 1 | Program/erase engine running |
| chk_addr | input | ADDR_W | Address to test against the protected range |
| status_byte | output | 8 | Last status value read |
| addr_protected | output | 1 | Registered result of the protection check |

## Verification
The in-line assertions check the following on every cycle. A locked register does not move under a status write. A status write without the enable latch changes nothing. The register stays frozen while busy. The clear-enable command drops the latch. The top protection level always reports a protected address. The unused bits stay zero. The bench scenarios are needed for the rest: the exact values stored after each allowed write, the pin and lock combinations that sit on either side of the gate, the quarter and half boundary addresses, and the capture-and-hold behaviour of the read path.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W   = 8;
  localparam int POS_BUSY = 0;
  localparam int POS_WEL  = 1;
  localparam int POS_LVL  = 2;
  localparam int POS_LOCK = 7;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } prot_lvl_e;

  typedef struct packed {
    logic      lock;
    prot_lvl_e lvl;
    logic      wel;
    logic      busy;
  } stat_t;
endpackage

// File: rtl/fsr_write_gate.sv
module fsr_write_gate (
  input  logic cmd_wrsr,
  input  logic wel,
  input  logic busy,
  input  logic wp_n,
  input  logic lock,
  output logic wrsr_ok,
  output logic mod_ok
);
  logic locked;

  always_comb begin
    locked  = lock & ~wp_n;
    mod_ok  = ~busy;
    wrsr_ok = cmd_wrsr & wel & ~busy & ~locked;
  end
endmodule

// File: rtl/fsr_status_regs.sv
module fsr_status_regs
  import fsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cmd_wren,
  input  logic  cmd_wrdi,
  input  logic  cmd_wrsr,
  input  logic  wrsr_ok,
  input  logic  mod_ok,
  input  logic  new_lock,
  input  logic  [1:0] new_lvl,
  input  logic  wp_n,
  input  logic  engine_busy,
  output stat_t stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
    end else begin
      stat.busy <= engine_busy;
      if (wrsr_ok) begin
        stat.lock <= new_lock;
        stat.lvl  <= prot_lvl_e'(new_lvl);
        stat.wel  <= 1'b0;
      end else if (mod_ok && cmd_wrdi) begin
        stat.wel <= 1'b0;
      end else if (mod_ok && cmd_wren) begin
        stat.wel <= 1'b1;
      end
    end
  end

  AST_LOCK_REFUSES: assert property (@(posedge clk) disable iff (rst)
    (cmd_wrsr && !wp_n && stat.lock) |=> ($stable(stat.lock) && $stable(stat.lvl))); // R5
  AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wrsr && !stat.wel) |=> ($stable(stat.lock) && $stable(stat.lvl))); // R4
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    stat.busy |=> ($stable(stat.lock) && $stable(stat.lvl) && $stable(stat.wel))); // R8
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cmd_wrdi && !stat.busy) |=> !stat.wel); // R3
  AST_BUSY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat.busy == $past(engine_busy))); // R2
endmodule

// File: rtl/fsr_region_map.sv
module fsr_region_map
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  prot_lvl_e         lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int MSB = ADDR_W - 1;

  logic hit_d;
  logic unused_low;
  assign unused_low = ^addr[MSB-2:0];

  always_comb begin
    case (lvl)
      LVL_QUARTER: hit_d = addr[MSB] & addr[MSB-1];
      LVL_HALF:    hit_d = addr[MSB];
      LVL_ALL:     hit_d = 1'b1;
      default:     hit_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= hit_d;
  end

  AST_FULL_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (lvl == LVL_ALL) |=> hit); // R10
  AST_NONE_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (lvl == LVL_NONE) |=> !hit); // R10
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_rdsr,
  input  logic [7:0]        wr_value,
  input  logic              wp_n,
  input  logic              engine_busy,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        status_byte,
  output logic              addr_protected
);
  stat_t stat;
  logic  wrsr_ok, mod_ok;
  logic  unused_val;
  logic [STAT_W-1:0] stat_vec;

  assign unused_val = ^{wr_value[6:4], wr_value[1:0]};

  fsr_write_gate gate_i (
    .cmd_wrsr (cmd_wrsr),
    .wel      (stat.wel),
    .busy     (stat.busy),
    .wp_n     (wp_n),
    .lock     (stat.lock),
    .wrsr_ok  (wrsr_ok),
    .mod_ok   (mod_ok)
  );

  fsr_status_regs regs_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_wren    (cmd_wren),
    .cmd_wrdi    (cmd_wrdi),
    .cmd_wrsr    (cmd_wrsr),
    .wrsr_ok     (wrsr_ok),
    .mod_ok      (mod_ok),
    .new_lock    (wr_value[POS_LOCK]),
    .new_lvl     (wr_value[POS_LVL+1:POS_LVL]),
    .wp_n        (wp_n),
    .engine_busy (engine_busy),
    .stat        (stat)
  );

  fsr_region_map #(.ADDR_W(ADDR_W)) map_i (
    .clk  (clk),
    .rst  (rst),
    .lvl  (stat.lvl),
    .addr (chk_addr),
    .hit  (addr_protected)
  );

  always_comb begin
    stat_vec = '0;
    stat_vec[POS_BUSY]            = stat.busy;
    stat_vec[POS_WEL]             = stat.wel;
    stat_vec[POS_LVL+1:POS_LVL]   = stat.lvl;
    stat_vec[POS_LOCK]            = stat.lock;
  end

  always_ff @(posedge clk) begin
    if (rst)           status_byte <= '0;
    else if (cmd_rdsr) status_byte <= stat_vec;
  end

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cmd_rdsr |=> $stable(status_byte)); // R9
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_byte[6:4] == 3'b000); // R2
endmodule

// File: tb/flash_status_guard_tb_top.sv
module flash_status_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_rdsr = 0;
  logic [7:0] wr_value = 8'h00;
  logic wp_n = 1'b1;
  logic engine_busy = 1'b0;
  logic [AW-1:0] chk_addr = '0;
  logic [7:0] status_byte;
  logic addr_protected;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .cmd_rdsr(cmd_rdsr), .wr_value(wr_value),
    .wp_n(wp_n), .engine_busy(engine_busy), .chk_addr(chk_addr),
    .status_byte(status_byte), .addr_protected(addr_protected)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_wren();
    cmd_wren = 1; tick(); cmd_wren = 0;
  endtask

  task automatic do_wrdi();
    cmd_wrdi = 1; tick(); cmd_wrdi = 0;
  endtask

  task automatic do_wrsr(input logic [7:0] v);
    wr_value = v; cmd_wrsr = 1; tick(); cmd_wrsr = 0;
  endtask

  task automatic read_status(output logic [7:0] v);
    cmd_rdsr = 1; tick(); cmd_rdsr = 0; v = status_byte;
  endtask

  task automatic probe(input string req, input logic [AW-1:0] a, input logic exp);
    chk_addr = a; tick();
    check(req, {7'd0, addr_protected}, {7'd0, exp});
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R1 status_byte", status_byte, 8'h00);
    check("R1 addr_protected", {7'd0, addr_protected}, 8'h00);
    read_status(s);
    check("R1 register", s, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] s;
    do_wren(); read_status(s);
    check("R3 wren sets latch", s, 8'h02);
    do_wrdi(); read_status(s);
    check("R3 wrdi clears latch", s, 8'h00);
  endtask

  task automatic t_write_rules();
    logic [7:0] s;
    wp_n = 1;
    do_wrsr(8'h8C); read_status(s);
    check("R4 no latch, unchanged", s, 8'h00);
    do_wren(); do_wrsr(8'hFF); read_status(s);
    check("R4 masked write clears latch", s, 8'h8C);
    wp_n = 0;
    do_wren(); do_wrsr(8'h04); read_status(s);
    check("R5 locked write refused", s, 8'h8E);
    wp_n = 1;
    do_wrsr(8'h04); read_status(s);
    check("R7 pin high overrides lock", s, 8'h04);
    wp_n = 0;
    do_wren(); do_wrsr(8'h88); read_status(s);
    check("R6 pin low, unlocked, executes", s, 8'h88);
    wp_n = 1;
    do_wren(); do_wrsr(8'h00); read_status(s);
    check("R7 unlock with pin high", s, 8'h00);
  endtask

  task automatic t_busy();
    logic [7:0] s;
    engine_busy = 1; tick();
    read_status(s);
    check("R2 busy bit follows engine", s, 8'h01);
    do_wren(); read_status(s);
    check("R8 wren ignored while busy", s, 8'h01);
    engine_busy = 0; tick();
    do_wren();
    engine_busy = 1; tick();
    do_wrsr(8'h8F); do_wrdi(); read_status(s);
    check("R8 wrsr/wrdi ignored while busy", s, 8'h03);
    engine_busy = 0; tick();
    do_wrsr(8'h03); read_status(s);
    check("R2 busy/latch not writable", s, 8'h00);
  endtask

  task automatic t_read_hold();
    logic [7:0] s;
    do_wren(); read_status(s);
    do_wrdi(); tick();
    check("R9 status_byte holds", status_byte, 8'h02);
    read_status(s);
    check("R9 fresh read", s, 8'h00);
  endtask

  task automatic t_regions();
    probe("R10 level 00 top addr", 20'hFFFFF, 1'b0);
    do_wren(); do_wrsr(8'h04);
    probe("R10 quarter at boundary", 20'hC0000, 1'b1);
    probe("R10 quarter below boundary", 20'hBFFFF, 1'b0);
    do_wren(); do_wrsr(8'h08);
    probe("R10 half at boundary", 20'h80000, 1'b1);
    probe("R10 half below boundary", 20'h7FFFF, 1'b0);
    do_wren(); do_wrsr(8'h0C);
    probe("R10 all protects zero", 20'h00000, 1'b1);
    do_wren(); do_wrsr(8'h00);
    chk_addr = 20'h00000; tick();
    chk_addr = 20'hFFFFF;
    check("R11 output not yet updated", {7'd0, addr_protected}, 8'h00);
    do_wren(); do_wrsr(8'h08); tick();
    check("R11 one clock later", {7'd0, addr_protected}, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_enable();
    t_write_rules();
    t_busy();
    t_read_hold();
    t_regions();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule